// File: doc/BRIEF.md
# Conditional Branch Target Unit

This block resolves PC-relative conditional branches. Each cycle it takes a 4-bit condition selector, the four arithmetic flags, the address of the instruction that follows the branch, and a signed 8-bit byte displacement. It decides whether the branch is taken and produces the address where execution continues. When the branch is taken, that address is the follow-on address plus the sign-extended displacement, wrapped within a 64 KiB space. Otherwise it is the follow-on address itself.

Displacements must be even. An odd displacement raises an error flag and cancels the branch, so execution falls through. The result is registered: outputs show the inputs sampled on the previous rising clock edge. The reset is asserted asynchronously and released synchronously inside the block.

Top module: `bcc_target_unit`

## Requirements
- R1: Selector 0x0 (always) is taken whenever the displacement is even. Selector 0x1 (never) is never taken.
- R2: Selectors 0x2 to 0xF decide from the flags, packed as flags_i = {N,Z,V,C} (bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C):
  - 0x2: C|Z = 0
  - 0x3: C|Z = 1
  - 0x4: C = 0
  - 0x5: C = 1
  - 0x6: Z = 0
  - 0x7: Z = 1
  - 0x8: V = 0
  - 0x9: V = 1
  - 0xA: N = 0
  - 0xB: N = 1
  - 0xC: N = V
  - 0xD: N != V
  - 0xE: Z = 0 and N = V
  - 0xF: Z = 1 or N != V
- R3: When the branch is not taken, target_o equals the follow-on address.
- R4: When the branch is taken, target_o equals (next_addr_i + sign-extended disp_i) mod 2^16, including wrap past 0xFFFF and below 0x0000.
- R5: An odd displacement (disp_i bit 0 = 1) sets misalign_o to 1, forces taken_o to 0, and gives target_o = next_addr_i. An even displacement gives misalign_o = 0.
- R6: While reset is held and until it is released, taken_o, misalign_o and target_o are all 0.
- R7: Outputs reflect the inputs sampled at the preceding rising clock edge: one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| next_addr_i | input | 16 | Address of the instruction after the branch |
| disp_i | input | 8 | Signed byte displacement |
| cond_i | input | 4 | Condition selector |
| flags_i | input | 4 | {N,Z,V,C} |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Address where execution continues |
| misalign_o | output | 1 | Odd displacement error |

## Verification
The assertions assume every input is a defined value on every clock edge after reset release. They also assume the inputs are held steady across that edge, so that each `$past` value is the vector that was actually registered. The stimulus meets both assumptions:
- Every input is changed only at falling edges.
- Every input is driven from time zero.

The stimulus sweeps every selector, every flag combination and every displacement. Follow-on addresses are chosen near both ends of the address space, so that wrap is exercised in both directions.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned FLAG_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_ALWAYS = 4'h0, SEL_NEVER = 4'h1, SEL_HI = 4'h2, SEL_LS = 4'h3,
    SEL_CC     = 4'h4, SEL_CS    = 4'h5, SEL_NE = 4'h6, SEL_EQ = 4'h7,
    SEL_VC     = 4'h8, SEL_VS    = 4'h9, SEL_PL = 4'hA, SEL_MI = 4'hB,
    SEL_GE     = 4'hC, SEL_LT    = 4'hD, SEL_GT = 4'hE, SEL_LE = 4'hF
  } sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/bcc_rst_sync.sv
module bcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcc_cond_eval.sv
module bcc_cond_eval
  import bcc_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              hit_o
);
  flags_t f;
  logic   sign_ok;

  assign f       = flags_t'(flags_i);
  assign sign_ok = ~(f.n ^ f.v);

  always_comb begin
    unique case (sel_e'(sel_i))
      SEL_ALWAYS: hit_o = 1'b1;
      SEL_NEVER:  hit_o = 1'b0;
      SEL_HI:     hit_o = ~(f.c | f.z);
      SEL_LS:     hit_o = f.c | f.z;
      SEL_CC:     hit_o = ~f.c;
      SEL_CS:     hit_o = f.c;
      SEL_NE:     hit_o = ~f.z;
      SEL_EQ:     hit_o = f.z;
      SEL_VC:     hit_o = ~f.v;
      SEL_VS:     hit_o = f.v;
      SEL_PL:     hit_o = ~f.n;
      SEL_MI:     hit_o = f.n;
      SEL_GE:     hit_o = sign_ok;
      SEL_LT:     hit_o = ~sign_ok;
      SEL_GT:     hit_o = ~f.z & sign_ok;
      SEL_LE:     hit_o = f.z | ~sign_ok;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcc_tgt_add.sv
module bcc_tgt_add #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_noext
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  // Sum is truncated to ADDR_W bits, giving modulo-2^ADDR_W wrap.
  assign sum_o = base_i + disp_ext;
endmodule

// File: rtl/bcc_target_unit.sv
module bcc_target_unit
  import bcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [SEL_W-1:0]  cond_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              misalign_o
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic              rst_sync_n;
  logic              cond_hit;
  logic [ADDR_W-1:0] branch_addr;
  logic              taken_d, misalign_d;
  logic [ADDR_W-1:0] target_d;
  logic              reg_en;

  bcc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bcc_cond_eval i_cond_eval (
    .sel_i   (cond_i),
    .flags_i (flags_i),
    .hit_o   (cond_hit)
  );

  bcc_tgt_add #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_tgt_add (
    .base_i (next_addr_i),
    .disp_i (disp_i),
    .sum_o  (branch_addr)
  );

  // Next-state logic
  always_comb begin
    reg_en     = 1'b1;
    misalign_d = disp_i[0];
    taken_d    = cond_hit & ~misalign_d;
    target_d   = taken_d ? branch_addr : next_addr_i;
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      taken_o    <= 1'b0;
      misalign_o <= 1'b0;
      target_o   <= '0;
    end else if (reg_en) begin
      taken_o    <= taken_d;
      misalign_o <= misalign_d;
      target_o   <= target_d;
    end
  end

  // Assertions
  assert_always_taken_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cond_i == SEL_ALWAYS && !disp_i[0]) |=> taken_o);

  assert_never_taken_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cond_i == SEL_NEVER) |=> !taken_o);

  assert_gt_blocked_by_z_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cond_i == SEL_GT && flags_i[2]) |=> !taken_o);

  assert_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cond_i == SEL_NEVER) |=> (target_o == $past(next_addr_i)));

  assert_taken_target_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cond_i == SEL_ALWAYS && !disp_i[0]) |=>
      (target_o == $past(next_addr_i) +
                   {{EXT_W{$past(disp_i[DISP_W-1])}}, $past(disp_i)}));

  assert_odd_disp_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    disp_i[0] |=> (misalign_o && !taken_o && target_o == $past(next_addr_i)));

  assert_no_error_even_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !disp_i[0] |=> !misalign_o);

  assert_taken_excl_error_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(taken_o && misalign_o));
endmodule

// File: tb/test_bcc_target_unit.sv
module test_bcc_target_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk;
  logic        rst_n;
  logic [15:0] next_addr;
  logic [7:0]  disp;
  logic [3:0]  cond;
  logic [3:0]  flags;
  logic        taken;
  logic [15:0] target;
  logic        misalign;

  int checks;
  int fails;
  int cycles;
  bit done;

  bcc_target_unit i_bcc_target_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .next_addr_i (next_addr),
    .disp_i      (disp),
    .cond_i      (cond),
    .flags_i     (flags),
    .taken_o     (taken),
    .target_o    (target),
    .misalign_o  (misalign)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Watchdog: an expired count is a failed check, then the summary line.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic bit exp_cond(input logic [3:0] c, input logic [3:0] f);
    bit n, z, v, cy;
    n = f[3]; z = f[2]; v = f[1]; cy = f[0];
    case (c)
      4'h0: return 1;
      4'h1: return 0;
      4'h2: return (cy | z) == 0;
      4'h3: return (cy | z) == 1;
      4'h4: return cy == 0;
      4'h5: return cy == 1;
      4'h6: return z == 0;
      4'h7: return z == 1;
      4'h8: return v == 0;
      4'h9: return v == 1;
      4'hA: return n == 0;
      4'hB: return n == 1;
      4'hC: return n == v;
      4'hD: return n != v;
      4'hE: return (z == 0) && (n == v);
      default: return (z == 1) || (n != v);
    endcase
  endfunction

  // Drive one vector at a falling edge and check the registered result
  // one rising edge later (R7).
  task automatic run_vec(input logic [15:0] a, input logic [7:0] d,
                         input logic [3:0] c, input logic [3:0] f);
    bit          odd, exp_t;
    int          sext;
    logic [15:0] exp_a;
    string       tag;
    odd   = d[0];
    exp_t = exp_cond(c, f) && !odd;
    sext  = (d[7]) ? int'(d) - 256 : int'(d);
    exp_a = exp_t ? 16'((int'(a) + sext + 65536) % 65536) : a;
    if (odd)             tag = "R5";
    else if (c == 4'h0 || c == 4'h1) tag = "R1";
    else if (exp_t)      tag = "R4/R2";
    else                 tag = "R3/R2";
    next_addr = a; disp = d; cond = c; flags = f;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (taken !== exp_t || target !== exp_a || misalign !== odd) begin
      fails++;
      $display("FAIL %s R7 cond=%h flags=%b disp=%h addr=%h: actual t=%b a=%h e=%b expected t=%b a=%h e=%b",
               tag, c, f, d, a, taken, target, misalign, exp_t, exp_a, odd);
    end
  endtask

  initial begin
    checks = 0; fails = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0;
    next_addr = 16'h1234; disp = 8'h10; cond = 4'h0; flags = 4'h0;
    repeat (3) @(negedge clk);
    // R6: reset state, with inputs that would otherwise give a taken branch
    checks++;
    if (taken !== 1'b0 || target !== 16'h0 || misalign !== 1'b0) begin
      fails++;
      $display("FAIL R6 reset: actual t=%b a=%h e=%b expected 0 0000 0",
               taken, target, misalign);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Wrap corners for R4
    run_vec(16'hFFFE, 8'h04, 4'h0, 4'h0);  // wraps to 0x0002
    run_vec(16'h0002, 8'hFC, 4'h0, 4'h0);  // wraps to 0xFFFE
    run_vec(16'h0000, 8'h80, 4'h0, 4'h0);  // 0xFF80
    run_vec(16'hFFFF, 8'h7E, 4'h0, 4'h0);  // 0x007D
    run_vec(16'h8000, 8'h01, 4'h0, 4'h0);  // odd: R5

    // Full sweep of selector, flags and displacement
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        for (int d = 0; d < 256; d++) begin
          logic [15:0] a;
          case ((c + f + d) % 4)
            0: a = 16'hFFF0 + 16'(d % 16);
            1: a = 16'h0000 + 16'(d % 16);
            2: a = 16'(c * 4099 + f * 257 + d * 131);
            default: a = 16'h7FF8 + 16'(f);
          endcase
          run_vec(a, 8'(d), 4'(c), 4'(f));
        end
      end
    end

    // R6: asynchronous reset in mid-operation clears the outputs
    next_addr = 16'h4000; disp = 8'h20; cond = 4'h0; flags = 4'h0;
    @(posedge clk);
    #1 rst_n = 1'b0;
    #1;
    checks++;
    if (taken !== 1'b0 || target !== 16'h0 || misalign !== 1'b0) begin
      fails++;
      $display("FAIL R6 async reset: actual t=%b a=%h e=%b expected 0 0000 0",
               taken, target, misalign);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule